// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block takes a requested output frequency and a reference frequency, both in whole MHz. It searches in hardware, step by step, for the PLL coefficients that best produce that frequency. The three coefficients are an input divider M, a feedback multiplier N and a post-divider index PL. Every candidate must keep the VCO and the comparison frequency (ref/M) inside fixed limits. The engine works on twice the requested frequency, because the PLL output is halved downstream.

A pulse on `start` latches both frequencies and begins the search. When the search ends, `done` pulses for one cycle. In that same cycle the outputs present the chosen coefficients, the absolute error of the best candidate and a flag that says whether any candidate qualified. All divisions are shared on one restoring divider, so a search takes a number of cycles that depends on the data.

Top module: `pll_coef_search`

## Requirements
- R1: While reset is high and after it is released, the outputs read done=0, busy=0, found=0, M=255, N=8, PL=1 and error=all ones (16'hFFFF).
- R2: PL is an index 0..14 into a post-divide ratio table. The ratios by index are 0:1, 1:2, 2:3, 3:4, 4:5, 5:6, 6:8, 7:10, 8:12, 9:16, 10:12, 11:16, 12:20, 13:24, 14:32.
- R3: Any reported result with found=1 has all of these properties:
  - M is in 1..255.
  - N is in 8..255.
  - ref/M (integer) is in 12..38.
  - ref*N/M (integer) is at least 1000 and at most max(2064, T+T/50), where T = 2*request.
- R4: The ratio bounds are hi = ceil(Vmax/Tv) and lo = floor(1000/Tv). Here Tv = T+T/50 and Vmax = max(2064, Tv). Both bounds are clamped to 1..32. Each bound then maps to the lowest index in 0..13 whose ratio is at least the bound, or to index 14 if no such index exists.
- R5: The search visits candidates in a fixed nesting order:
  - Outer loop: the index, from lo to hi.
  - Middle loop: M, rising from 1. The M loop stops when ref/M < 12 or when floor(ratio*T*M/ref) > 255. An M with ref/M > 38 is skipped.
  - Inner loop: N, from floor to ceil of ratio*T*M/ref. An N below 8 is skipped, and the N loop stops at an N above 255.
  
  A candidate's error is |(VCO+ratio/2)/ratio - T|. A candidate replaces the best only if its error is strictly smaller.
- R6: A candidate with zero error ends the search at once. That candidate is the result.
- R7: If no candidate qualifies, the result is M=255, N=8, PL=1 and error=16'hFFFF, with found=0.
- R8: At done, found is 1 exactly when the error is not all ones.
- R9: A start pulse that arrives while busy=1 is ignored, and the search in progress completes with its own inputs.
- R10: done is high for exactly one cycle. The result outputs change only in a cycle in which done is high.
- R11: In the cycle done is high, busy is 0 and a start in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| req_mhz | input | 12 | Requested output frequency, MHz |
| ref_mhz | input | 8 | Reference frequency, MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse, result valid |
| found | output | 1 | A candidate met all limits |
| m_div | output | 8 | Chosen input divider M |
| n_mul | output | 8 | Chosen feedback multiplier N |
| pl_idx | output | 4 | Chosen post-divider table index |
| best_err | output | 16 | Absolute error of the chosen result, MHz |

## Verification
Two events can coincide at the end of a search: the done pulse that publishes one result and the start that opens the next search. The bench waits for done at a falling edge and raises start in that same cycle with new frequencies. It then requires two things. The published result must match the first job, and the following done must carry the result computed for the second job. A separate run pulses start with other inputs in the middle of a search, and the result must still belong to the original request.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_TV, S_HI, S_LO, S_IDX, S_PL, S_M, S_U,
    S_N, S_NCHK, S_V, S_E, S_WAIT, S_FIN
  } pcs_state_e;

  localparam int IDX_LAST = 14;

  // Post-divide ratio for each table index (non-monotonic above index 9)
  function automatic logic [5:0] ratio_of(input logic [3:0] idx);
    case (idx)
      4'd0:    ratio_of = 6'd1;
      4'd1:    ratio_of = 6'd2;
      4'd2:    ratio_of = 6'd3;
      4'd3:    ratio_of = 6'd4;
      4'd4:    ratio_of = 6'd5;
      4'd5:    ratio_of = 6'd6;
      4'd6:    ratio_of = 6'd8;
      4'd7:    ratio_of = 6'd10;
      4'd8:    ratio_of = 6'd12;
      4'd9:    ratio_of = 6'd16;
      4'd10:   ratio_of = 6'd12;
      4'd11:   ratio_of = 6'd16;
      4'd12:   ratio_of = 6'd20;
      4'd13:   ratio_of = 6'd24;
      default: ratio_of = 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] clamp_bound(input logic [31:0] q, input int lo, input int hi);
    if (q < 32'(lo))      clamp_bound = 6'(lo);
    else if (q > 32'(hi)) clamp_bound = 6'(hi);
    else                  clamp_bound = q[5:0];
  endfunction

endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CNT_W = $clog2(W) + 1;

  logic [W-1:0]     den_r;
  logic [CNT_W-1:0] cnt;
  logic [W:0]       shl;
  logic             ge;
  logic [W:0]       sub;

  always_comb begin
    shl = {rem, quo[W-1]};
    sub = shl - {1'b0, den_r};
    ge  = (shl >= {1'b0, den_r});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
      rem   <= '0;
      den_r <= '0;
      cnt   <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy  <= 1'b1;
        quo   <= num;
        rem   <= '0;
        den_r <= den;
        cnt   <= '0;
      end else if (busy) begin
        rem <= ge ? sub[W-1:0] : shl[W-1:0];
        quo <= {quo[W-2:0], ge};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5: every quotient handed to the search carries a proper remainder
  a_r5_rem_below_den: assert property (@(posedge clk) disable iff (rst)
    (done && den_r != '0) |-> (rem < den_r));

endmodule

// File: rtl/pcs_ratio_lut.sv
module pcs_ratio_lut (
  input  logic [3:0] idx,
  output logic [5:0] ratio
);
  import pcs_pkg::*;
  assign ratio = ratio_of(idx);
endmodule

// File: rtl/pcs_bound_map.sv
module pcs_bound_map (
  input  logic [5:0] bound,
  output logic [3:0] idx
);
  import pcs_pkg::*;
  always_comb begin
    idx = 4'(IDX_LAST);
    for (int i = IDX_LAST - 1; i >= 0; i--) begin
      if (ratio_of(4'(i)) >= bound) idx = 4'(i);
    end
  end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search #(
  parameter int FW      = 12,
  parameter int RW      = 8,
  parameter int DW      = 32,
  parameter int CW      = 8,
  parameter int EW      = 16,
  parameter int VCO_MIN = 1000,
  parameter int VCO_MAX = 2064,
  parameter int CMP_MIN = 12,
  parameter int CMP_MAX = 38,
  parameter int M_MIN   = 1,
  parameter int M_MAX   = 255,
  parameter int N_MIN   = 8,
  parameter int N_MAX   = 255,
  parameter int R_MIN   = 1,
  parameter int R_MAX   = 32,
  parameter int SLOPE   = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] req_mhz,
  input  logic [RW-1:0] ref_mhz,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [CW-1:0] m_div,
  output logic [CW-1:0] n_mul,
  output logic [3:0]    pl_idx,
  output logic [EW-1:0] best_err
);
  import pcs_pkg::*;

  localparam logic [3:0] PL_DEF = 4'd1;

  pcs_state_e st, ret_st;
  logic [DW-1:0] tgt_q, ref_q, tvco_q, maxv_q, tv_q, m_q, n_q, n2_q;
  logic [5:0]    bnd [2];
  logic [3:0]    bidx [2];
  logic [3:0]    pl_q, hi_idx_q;
  logic [5:0]    ratio;
  logic [CW-1:0] best_m, best_n;
  logic [3:0]    best_pl;
  logic [EW-1:0] best_e;
  logic          hit;

  logic          dv_go, dv_busy, dv_done;
  logic [DW-1:0] dv_num, dv_den, dv_q, dv_r;
  logic [DW-1:0] tvco_n, maxv_n, diff_n;

  pcs_divider #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .go(dv_go), .num(dv_num), .den(dv_den),
    .busy(dv_busy), .done(dv_done), .quo(dv_q), .rem(dv_r)
  );

  pcs_ratio_lut u_lut (.idx(pl_q), .ratio(ratio));

  // bound 0 = low bound, bound 1 = high bound
  for (genvar g = 0; g < 2; g++) begin : g_bound
    pcs_bound_map u_map (.bound(bnd[g]), .idx(bidx[g]));
  end

  always_comb begin
    tvco_n = tgt_q + dv_q;
    maxv_n = (tvco_n > DW'(VCO_MAX)) ? tvco_n : DW'(VCO_MAX);
    diff_n = (dv_q >= tgt_q) ? (dv_q - tgt_q) : (tgt_q - dv_q);
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  ret_st <= S_IDLE;
      tgt_q <= '0;   ref_q <= '0;  tvco_q <= '0; maxv_q <= '0;
      tv_q <= '0;    m_q <= '0;    n_q <= '0;    n2_q <= '0;
      bnd[0] <= 6'd1; bnd[1] <= 6'd1;
      pl_q <= '0;    hi_idx_q <= '0;
      best_m <= CW'(M_MAX); best_n <= CW'(N_MIN); best_pl <= PL_DEF;
      best_e <= '1;  hit <= 1'b0;
      dv_go <= 1'b0; dv_num <= '0; dv_den <= '0;
      done <= 1'b0;  found <= 1'b0;
      m_div <= CW'(M_MAX); n_mul <= CW'(N_MIN); pl_idx <= PL_DEF;
      best_err <= '1;
    end else begin
      dv_go <= 1'b0;
      done  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tgt_q   <= DW'(req_mhz) << 1;
          ref_q   <= DW'(ref_mhz);
          hit     <= 1'b0;
          best_m  <= CW'(M_MAX);
          best_n  <= CW'(N_MIN);
          best_pl <= PL_DEF;
          best_e  <= '1;
          dv_num  <= DW'(req_mhz) << 1;
          dv_den  <= DW'(SLOPE);
          dv_go   <= 1'b1;
          ret_st  <= S_TV;
          st      <= S_WAIT;
        end
        S_TV: begin
          tvco_q <= tvco_n;
          maxv_q <= maxv_n;
          dv_num <= maxv_n + tvco_n - 1'b1;
          dv_den <= tvco_n;
          dv_go  <= 1'b1;
          ret_st <= S_HI;
          st     <= S_WAIT;
        end
        S_HI: begin
          bnd[1] <= clamp_bound(dv_q, R_MIN, R_MAX);
          dv_num <= DW'(VCO_MIN);
          dv_den <= tvco_q;
          dv_go  <= 1'b1;
          ret_st <= S_LO;
          st     <= S_WAIT;
        end
        S_LO: begin
          bnd[0] <= clamp_bound(dv_q, R_MIN, R_MAX);
          st     <= S_IDX;
        end
        S_IDX: begin
          pl_q     <= bidx[0];
          hi_idx_q <= bidx[1];
          st       <= S_PL;
        end
        S_PL: begin
          if (pl_q > hi_idx_q) st <= S_FIN;
          else begin
            tv_q <= tgt_q * DW'(ratio);
            m_q  <= DW'(M_MIN);
            st   <= S_M;
          end
        end
        S_M: begin
          if (m_q > DW'(M_MAX)) begin
            pl_q <= pl_q + 1'b1;
            st   <= S_PL;
          end else begin
            dv_num <= ref_q;
            dv_den <= m_q;
            dv_go  <= 1'b1;
            ret_st <= S_U;
            st     <= S_WAIT;
          end
        end
        S_U: begin
          if (dv_q < DW'(CMP_MIN)) begin
            pl_q <= pl_q + 1'b1;
            st   <= S_PL;
          end else if (dv_q > DW'(CMP_MAX)) begin
            m_q <= m_q + 1'b1;
            st  <= S_M;
          end else begin
            dv_num <= tv_q * m_q;
            dv_den <= ref_q;
            dv_go  <= 1'b1;
            ret_st <= S_N;
            st     <= S_WAIT;
          end
        end
        S_N: begin
          if (dv_q > DW'(N_MAX)) begin
            pl_q <= pl_q + 1'b1;
            st   <= S_PL;
          end else begin
            n_q  <= dv_q;
            n2_q <= dv_q + DW'(dv_r != '0);
            st   <= S_NCHK;
          end
        end
        S_NCHK: begin
          if (n_q > n2_q || n_q > DW'(N_MAX)) begin
            m_q <= m_q + 1'b1;
            st  <= S_M;
          end else if (n_q < DW'(N_MIN)) begin
            n_q <= n_q + 1'b1;
          end else begin
            dv_num <= ref_q * n_q;
            dv_den <= m_q;
            dv_go  <= 1'b1;
            ret_st <= S_V;
            st     <= S_WAIT;
          end
        end
        S_V: begin
          if (dv_q >= DW'(VCO_MIN) && dv_q <= maxv_q) begin
            dv_num <= dv_q + DW'(ratio >> 1);
            dv_den <= DW'(ratio);
            dv_go  <= 1'b1;
            ret_st <= S_E;
            st     <= S_WAIT;
          end else begin
            n_q <= n_q + 1'b1;
            st  <= S_NCHK;
          end
        end
        S_E: begin
          if (diff_n < DW'(best_e)) begin
            best_m  <= m_q[CW-1:0];
            best_n  <= n_q[CW-1:0];
            best_pl <= pl_q;
            best_e  <= diff_n[EW-1:0];
            hit     <= 1'b1;
          end
          if (diff_n == '0) st <= S_FIN;
          else begin
            n_q <= n_q + 1'b1;
            st  <= S_NCHK;
          end
        end
        S_WAIT: if (dv_done) st <= ret_st;
        S_FIN: begin
          m_div    <= best_m;
          n_mul    <= best_n;
          pl_idx   <= best_pl;
          best_err <= best_e;
          found    <= hit;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: single-cycle completion pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: results only move together with done
  a_r10_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (done || ($stable(m_div) && $stable(n_mul) && $stable(pl_idx)
                        && $stable(best_err) && $stable(found))));

  // R8: found flag agrees with the error value
  a_r8_found_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (found == (best_err != '1)));

  // R3: qualified coefficients lie in their ranges
  a_r3_coef_range: assert property (@(posedge clk) disable iff (rst)
    (done && found) |-> (m_div >= CW'(M_MIN) && n_mul >= CW'(N_MIN) && pl_idx <= 4'(IDX_LAST)));

  // R11: engine is idle while the result is announced
  a_r11_idle_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/test_pll_coef_search.sv
`timescale 1ns/1ps
module test_pll_coef_search;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [11:0] req_mhz = '0;
  logic [7:0]  ref_mhz = '0;
  logic        busy, done, found;
  logic [7:0]  m_div, n_mul;
  logic [3:0]  pl_idx;
  logic [15:0] best_err;

  always #10 clk = ~clk;

  pll_coef_search i_pll_coef_search (
    .clk(clk), .rst(rst), .start(start), .req_mhz(req_mhz), .ref_mhz(ref_mhz),
    .busy(busy), .done(done), .found(found), .m_div(m_div), .n_mul(n_mul),
    .pl_idx(pl_idx), .best_err(best_err)
  );

  typedef struct {
    int    m, n, pl, err, fnd, rf, req;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   prev_done = 1'b0;
  int   dones = 0;

  function automatic int ratio_tab(int i);
    int t[15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};
    return t[i];
  endfunction

  function automatic int first_idx(int b);
    for (int i = 0; i < 14; i++) if (ratio_tab(i) >= b) return i;
    return 14;
  endfunction

  function automatic int clampr(int v);
    return (v < 1) ? 1 : ((v > 32) ? 32 : v);
  endfunction

  // Search model written from R4..R7
  function automatic exp_t model(int req, int rf, string tag);
    exp_t e;
    int tgt, tvco, maxv, hb, lb, li, hi;
    tgt  = 2 * req;
    tvco = tgt + tgt / 50;
    maxv = (tvco > 2064) ? tvco : 2064;
    hb = (tvco == 0) ? 32 : clampr((maxv + tvco - 1) / tvco);
    lb = (tvco == 0) ? 32 : clampr(1000 / tvco);
    li = first_idx(lb);
    hi = first_idx(hb);
    e.m = 255; e.n = 8; e.pl = 1; e.err = 65535; e.fnd = 0;
    e.rf = rf; e.req = req; e.tag = tag;
    for (int pl = li; pl <= hi; pl++) begin
      int r, tv;
      r  = ratio_tab(pl);
      tv = tgt * r;
      for (int m = 1; m <= 255; m++) begin
        int n0, n2;
        if (rf / m < 12) break;
        if (rf / m > 38) continue;
        n0 = tv * m / rf;
        n2 = (tv * m + rf - 1) / rf;
        if (n0 > 255) break;
        for (int nn = n0; nn <= n2; nn++) begin
          int vco, lwv, d;
          if (nn < 8) continue;
          if (nn > 255) break;
          vco = rf * nn / m;
          if (vco >= 1000 && vco <= maxv) begin
            lwv = (vco + r / 2) / r;
            d = (lwv > tgt) ? lwv - tgt : tgt - lwv;
            if (d < e.err) begin
              e.err = d; e.m = m; e.n = nn; e.pl = pl; e.fnd = 1;
              if (d == 0) return e;
            end
          end
        end
      end
    end
    return e;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: called at a falling edge; pushes expected result
  task automatic launch(int req, int rf, string tag);
    start   = 1'b1;
    req_mhz = 12'(req);
    ref_mhz = 8'(rf);
    q.push_back(model(req, rf, tag));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  // Monitor: pops and compares at each completion
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) check(!done, "R10", "done width", int'(done), 0);
      if (done) begin
        dones++;
        if (q.size() == 0) check(1'b0, "R9", "unexpected done", dones, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          last = e;
          check(int'(m_div) == e.m, e.tag, "M", int'(m_div), e.m);
          check(int'(n_mul) == e.n, e.tag, "N", int'(n_mul), e.n);
          check(int'(pl_idx) == e.pl, e.tag, "PL", int'(pl_idx), e.pl);
          check(int'(best_err) == e.err, e.tag, "error", int'(best_err), e.err);
          check(int'(found) == e.fnd, "R8", "found", int'(found), e.fnd);
          check(!busy, "R11", "busy at done", int'(busy), 0);
          if (found) begin
            int tgt, tvco, maxv, vco, u;
            tgt  = 2 * e.req;
            tvco = tgt + tgt / 50;
            maxv = (tvco > 2064) ? tvco : 2064;
            vco  = e.rf * int'(n_mul) / int'(m_div);
            u    = e.rf / int'(m_div);
            check(vco >= 1000 && vco <= maxv, "R3", "vco", vco, maxv);
            check(u >= 12 && u <= 38, "R3", "comparison freq", u, 12);
          end
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 0 && busy == 0 && found == 0, "R1", "flags", int'({done, busy, found}), 0);
    check(m_div == 8'd255 && n_mul == 8'd8, "R1", "M/N", int'(m_div), 255);
    check(pl_idx == 4'd1 && best_err == 16'hFFFF, "R1", "PL/err", int'(best_err), 65535);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", int'(busy), 0);

    // R6: exact hit at the first candidate: M=1 N=100 PL=0 error 0
    launch(600, 12, "R6");
    wait_done();
    check(m_div == 8'd1 && n_mul == 8'd100 && pl_idx == 4'd0 && best_err == 16'd0,
          "R6", "exact result M", int'(m_div), 1);

    // R2 R5: low request reaches the non-monotonic part of the table
    launch(36, 26, "R2");
    wait_done();
    launch(200, 100, "R5");
    wait_done();
    launch(100, 200, "R5");
    wait_done();
    // R4: target VCO above the VCO maximum raises the limit
    launch(1500, 38, "R4");
    wait_done();
    // R7: reference too small for any M
    launch(300, 5, "R7");
    wait_done();

    // R10: outputs hold after done
    repeat (20) @(negedge clk);
    check(int'(m_div) == last.m && int'(n_mul) == last.n && int'(best_err) == last.err,
          "R10", "hold M", int'(m_div), last.m);

    // R9: start while busy with other inputs is ignored
    launch(330, 27, "R9");
    repeat (40) @(negedge clk);
    check(busy, "R9", "busy mid search", int'(busy), 1);
    start = 1'b1; req_mhz = 12'd600; ref_mhz = 8'd12;
    @(negedge clk);
    start = 1'b0;
    // R11: start in the same cycle as done
    wait_done();
    launch(324, 27, "R11");
    wait_done();
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R11", "pending jobs", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule